// File: doc/BRIEF.md
# SCSI Sequencer Command Decoder

This block sits between the register file of a SCSI initiator and its bus phase engine. When software writes a command byte to the sequence register, the decoder splits the byte into its fields. It works out how many bytes the next phase will move and hands the phase engine a start pulse together with a starting state code.

Commands that need no bus phase are carried out here in a single cycle. These are bus free, parity enable and disable, reselect enable and disable, soft reset and FIFO flush. Each of them becomes a one-cycle strobe to the FIFO, to the interrupt logic or to the bus-line driver.

Every output is registered. The result of a write appears in the cycle after the clock edge that captures the write.

Top module: `scsi_seq_cmd_decoder`

## Requirements
- R1: One cycle after a write, `curCmd` holds the written byte and `dmaMode` equals its bit 7. The opcode is bits 3:0: 0 no-op, 1 arbitrate, 2 select, 3 command, 4 status, 5 data out, 6 data in, 7 message out, 8 message in, 9 bus free, 10 parity on, 11 parity off, 12 reselect on, 13 reselect off, 14 soft reset, 15 flush.
- R2: Every command write, whatever its opcode, produces a one-cycle `irqDoneClr` pulse one cycle after the write.
- R3: A select command loads `atnReq` from bit 5 of the byte. No other command changes `atnReq`.
- R4: Opcodes 1 to 8 give a one-cycle `seqStart` with these `seqState` codes: 1 arbitrate, 2 select, 3 send command, 4 receive status, 5 transfer (both data opcodes), 6 send message, 7 receive message. `seqState` is 0 whenever `seqStart` is low.
- R5: For data out and data in, `xferLen` is `xferCount`, except that a count of zero gives 65536. For status, message out and message in, `xferLen` is `xferCount` as written. All other opcodes leave `xferLen` unchanged.
- R6: The command opcode starts the sequencer only when `fifoLevel` is nonzero. With an empty FIFO it produces no start.
- R7: Bus free pulses `ackRelease`. If `busyLine` is high it pulses `excPhaseSet` and `irqExcSet` and not `irqDoneSet`. Otherwise it pulses `irqDoneSet` only.
- R8: Soft reset pulses `softReset`, `fifoFlush` and `irqDoneSet`, and leaves `curCmd` and `dmaMode` at 0. `parityEn`, `atnReq` and `xferLen` keep their values.
- R9: Reselect enable and reselect disable pulse `irqDoneSet` and no other strobe apart from `irqDoneClr`.
- R10: Flush pulses `fifoFlush` and no done or exception strobe.
- R11: Parity on sets `parityEn` and parity off clears it. The flag holds across all other commands.
- R12: Phase lines are encoded {MSG, C/D, I/O}: data out 000, data in 001, command 010, status 011, message out 110, message in 111. Opcodes 3 to 8 whose expected phase differs from `busPhase` pulse `phaseWarn`, and the start still proceeds.
- R13: After reset every output is 0. A no-op, or a cycle without a write, pulses nothing except, for the no-op, `irqDoneClr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrite | input | 1 | Command byte write strobe |
| cmdByte | input | 8 | Written command byte |
| xferCount | input | CNT_W | Programmed transfer count |
| fifoLevel | input | FIFO_W | Current FIFO occupancy |
| busyLine | input | 1 | Sensed BSY line |
| busPhase | input | 3 | Sensed {MSG, C/D, I/O} lines |
| seqStart | output | 1 | Start pulse to the phase engine |
| seqState | output | 4 | Starting state code, valid with seqStart |
| xferLen | output | CNT_W+1 | Bytes to move in the started phase |
| curCmd | output | 8 | Last command byte (0 after soft reset) |
| dmaMode | output | 1 | DMA flag of the current command |
| atnReq | output | 1 | Assert ATN during selection |
| parityEn | output | 1 | Parity checking enabled |
| phaseWarn | output | 1 | Pulse: bus phase differs from the command |
| ackRelease | output | 1 | Pulse: release ACK |
| fifoFlush | output | 1 | Pulse: zero the FIFO count |
| softReset | output | 1 | Pulse: soft reset of the controller |
| irqDoneClr | output | 1 | Pulse: clear the command-done interrupt |
| irqDoneSet | output | 1 | Pulse: set the command-done interrupt |
| irqExcSet | output | 1 | Pulse: set the exception interrupt |
| excPhaseSet | output | 1 | Pulse: set the phase-mismatch exception |

## Verification
Every result of a write is due exactly one cycle after the capturing edge, because the decode is combinational and each output passes through a single register. The bench drives a write on a falling edge and lets the next rising edge capture it. It drops the write strobe and samples all outputs on the following falling edge. It then samples once more a full cycle later to confirm that every pulse lasted one cycle and that the latched state held. The sweep covers all 256 command bytes under eight combinations of busy, FIFO level, count and phase match.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;

  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_ARB      = 4'd1,
    OP_SEL      = 4'd2,
    OP_CMD      = 4'd3,
    OP_STAT     = 4'd4,
    OP_DOUT     = 4'd5,
    OP_DIN      = 4'd6,
    OP_MOUT     = 4'd7,
    OP_MIN      = 4'd8,
    OP_BFREE    = 4'd9,
    OP_PAR_ON   = 4'd10,
    OP_PAR_OFF  = 4'd11,
    OP_RSEL_ON  = 4'd12,
    OP_RSEL_OFF = 4'd13,
    OP_SRESET   = 4'd14,
    OP_FLUSH    = 4'd15
  } seqOp_e;

  typedef enum logic [3:0] {
    SQ_IDLE    = 4'd0,
    SQ_ARB     = 4'd1,
    SQ_SEL     = 4'd2,
    SQ_SENDCMD = 4'd3,
    SQ_RCVSTAT = 4'd4,
    SQ_XFER    = 4'd5,
    SQ_SENDMSG = 4'd6,
    SQ_RCVMSG  = 4'd7
  } seqState_e;

  typedef enum logic [1:0] {
    LEN_HOLD = 2'd0,
    LEN_RAW  = 2'd1,
    LEN_DATA = 2'd2
  } lenMode_e;

  // Phase line encoding {MSG, C/D, I/O}
  localparam logic [2:0] PH_DOUT = 3'b000;
  localparam logic [2:0] PH_DIN  = 3'b001;
  localparam logic [2:0] PH_CMD  = 3'b010;
  localparam logic [2:0] PH_STAT = 3'b011;
  localparam logic [2:0] PH_MOUT = 3'b110;
  localparam logic [2:0] PH_MIN  = 3'b111;

  // Strobes from control to datapath
  typedef struct packed {
    logic      wr;
    logic      start;
    seqState_e state;
    lenMode_e  lenMode;
    logic      loadAtn;
    logic      atnVal;
    logic      ackRel;
    logic      doneSet;
    logic      excSet;
    logic      flush;
    logic      sreset;
    logic      parSet;
    logic      parClr;
    logic      warn;
  } seqStrobes_t;

endpackage

// File: rtl/seqcmd_ctrl.sv
module seqcmd_ctrl
  import seqcmd_pkg::*;
#(
  parameter int FIFO_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrite,
  input  logic [3:0]        cmdOp,
  input  logic              atnFlag,
  input  logic [FIFO_W-1:0] fifoLevel,
  input  logic              busyLine,
  input  logic [2:0]        busPhase,
  output seqStrobes_t       strobes
);

  seqOp_e     op;
  logic       fifoNotEmpty;
  logic       hasPhase;
  logic [2:0] expPhase;

  assign op           = seqOp_e'(cmdOp);
  assign fifoNotEmpty = |fifoLevel;

  always_comb begin
    strobes  = '0;
    hasPhase = 1'b0;
    expPhase = PH_DOUT;
    if (cmdWrite) begin
      strobes.wr = 1'b1;
      case (op)
        OP_ARB: begin
          strobes.start = 1'b1;
          strobes.state = SQ_ARB;
        end
        OP_SEL: begin
          strobes.start   = 1'b1;
          strobes.state   = SQ_SEL;
          strobes.loadAtn = 1'b1;
          strobes.atnVal  = atnFlag;
        end
        OP_CMD: begin
          strobes.start = fifoNotEmpty;
          strobes.state = fifoNotEmpty ? SQ_SENDCMD : SQ_IDLE;
          hasPhase      = 1'b1;
          expPhase      = PH_CMD;
        end
        OP_STAT: begin
          strobes.start   = 1'b1;
          strobes.state   = SQ_RCVSTAT;
          strobes.lenMode = LEN_RAW;
          hasPhase        = 1'b1;
          expPhase        = PH_STAT;
        end
        OP_DOUT: begin
          strobes.start   = 1'b1;
          strobes.state   = SQ_XFER;
          strobes.lenMode = LEN_DATA;
          hasPhase        = 1'b1;
          expPhase        = PH_DOUT;
        end
        OP_DIN: begin
          strobes.start   = 1'b1;
          strobes.state   = SQ_XFER;
          strobes.lenMode = LEN_DATA;
          hasPhase        = 1'b1;
          expPhase        = PH_DIN;
        end
        OP_MOUT: begin
          strobes.start   = 1'b1;
          strobes.state   = SQ_SENDMSG;
          strobes.lenMode = LEN_RAW;
          hasPhase        = 1'b1;
          expPhase        = PH_MOUT;
        end
        OP_MIN: begin
          strobes.start   = 1'b1;
          strobes.state   = SQ_RCVMSG;
          strobes.lenMode = LEN_RAW;
          hasPhase        = 1'b1;
          expPhase        = PH_MIN;
        end
        OP_BFREE: begin
          strobes.ackRel  = 1'b1;
          strobes.excSet  = busyLine;
          strobes.doneSet = !busyLine;
        end
        OP_PAR_ON:   strobes.parSet  = 1'b1;
        OP_PAR_OFF:  strobes.parClr  = 1'b1;
        OP_RSEL_ON:  strobes.doneSet = 1'b1;
        OP_RSEL_OFF: strobes.doneSet = 1'b1;
        OP_SRESET: begin
          strobes.sreset  = 1'b1;
          strobes.flush   = 1'b1;
          strobes.doneSet = 1'b1;
        end
        OP_FLUSH:    strobes.flush   = 1'b1;
        default: ;
      endcase
      strobes.warn = hasPhase && (busPhase != expPhase);
    end
  end

  // R6: an empty FIFO blocks a command-phase start
  assert_cmd_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && cmdOp == 4'd3 && fifoLevel == '0) |-> !strobes.start);

  // R12: a mismatch warning never stops a start on a non-command phase opcode
  assert_warn_proceeds_R12: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.warn && op != OP_CMD) |-> strobes.start);

  // R7: a bus free never reports both done and exception
  assert_bfree_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.excSet |-> (!strobes.doneSet && strobes.ackRel));

endmodule

// File: rtl/seqcmd_datapath.sv
module seqcmd_datapath
  import seqcmd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobes_t      strobes,
  input  logic [7:0]       cmdByte,
  input  logic [CNT_W-1:0] xferCount,
  output logic             seqStart,
  output logic [3:0]       seqState,
  output logic [CNT_W:0]   xferLen,
  output logic [7:0]       curCmd,
  output logic             dmaMode,
  output logic             atnReq,
  output logic             parityEn,
  output logic             phaseWarn,
  output logic             ackRelease,
  output logic             fifoFlush,
  output logic             softReset,
  output logic             irqDoneClr,
  output logic             irqDoneSet,
  output logic             irqExcSet,
  output logic             excPhaseSet
);

  localparam int LEN_W = CNT_W + 1;
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(1) << CNT_W;

  logic [LEN_W-1:0] rawLen;
  logic [LEN_W-1:0] dataLen;
  logic             pastValid;

  assign rawLen  = {1'b0, xferCount};
  assign dataLen = (xferCount == '0) ? FULL_LEN : rawLen;
  assign dmaMode = curCmd[7];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqStart    <= 1'b0;
      seqState    <= SQ_IDLE;
      xferLen     <= '0;
      curCmd      <= '0;
      atnReq      <= 1'b0;
      parityEn    <= 1'b0;
      phaseWarn   <= 1'b0;
      ackRelease  <= 1'b0;
      fifoFlush   <= 1'b0;
      softReset   <= 1'b0;
      irqDoneClr  <= 1'b0;
      irqDoneSet  <= 1'b0;
      irqExcSet   <= 1'b0;
      excPhaseSet <= 1'b0;
      pastValid   <= 1'b0;
    end else begin
      pastValid   <= 1'b1;
      seqStart    <= strobes.start;
      seqState    <= strobes.start ? strobes.state : SQ_IDLE;
      phaseWarn   <= strobes.warn;
      ackRelease  <= strobes.ackRel;
      fifoFlush   <= strobes.flush;
      softReset   <= strobes.sreset;
      irqDoneClr  <= strobes.wr;
      irqDoneSet  <= strobes.doneSet;
      irqExcSet   <= strobes.excSet;
      excPhaseSet <= strobes.excSet;
      if (strobes.wr)      curCmd <= strobes.sreset ? 8'h00 : cmdByte;
      if (strobes.loadAtn) atnReq <= strobes.atnVal;
      if (strobes.parSet)      parityEn <= 1'b1;
      else if (strobes.parClr) parityEn <= 1'b0;
      case (strobes.lenMode)
        LEN_RAW:  xferLen <= rawLen;
        LEN_DATA: xferLen <= dataLen;
        default:  ;
      endcase
    end
  end

  // R2: each write is followed by a done-clear pulse
  assert_done_clr_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(strobes.wr)) |-> irqDoneClr);

  // R4: a state code only accompanies a start
  assert_state_code_R4: assert property (@(posedge clk) disable iff (!rstN)
    seqStart == (seqState != 4'd0));

  // R5: a started data transfer never has a zero length
  assert_data_len_R5: assert property (@(posedge clk) disable iff (!rstN)
    (seqStart && seqState == 4'd5) |-> (xferLen != '0));

  // R7: the exception pair arrives together with the ACK release
  assert_exc_pair_R7: assert property (@(posedge clk) disable iff (!rstN)
    excPhaseSet |-> (irqExcSet && ackRelease && !irqDoneSet));

  // R8: a soft reset flushes, reports done and clears the command
  assert_sreset_R8: assert property (@(posedge clk) disable iff (!rstN)
    softReset |-> (fifoFlush && irqDoneSet && curCmd == 8'h00));

  // R11: the parity flag moves only on its own commands
  assert_parity_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(strobes.parSet) && !$past(strobes.parClr)) |-> $stable(parityEn));

endmodule

// File: rtl/scsi_seq_cmd_decoder.sv
module scsi_seq_cmd_decoder
  import seqcmd_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FIFO_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrite,
  input  logic [7:0]        cmdByte,
  input  logic [CNT_W-1:0]  xferCount,
  input  logic [FIFO_W-1:0] fifoLevel,
  input  logic              busyLine,
  input  logic [2:0]        busPhase,
  output logic              seqStart,
  output logic [3:0]        seqState,
  output logic [CNT_W:0]    xferLen,
  output logic [7:0]        curCmd,
  output logic              dmaMode,
  output logic              atnReq,
  output logic              parityEn,
  output logic              phaseWarn,
  output logic              ackRelease,
  output logic              fifoFlush,
  output logic              softReset,
  output logic              irqDoneClr,
  output logic              irqDoneSet,
  output logic              irqExcSet,
  output logic              excPhaseSet
);

  localparam int ATN_BIT = 5;

  seqStrobes_t strobes;

  seqcmd_ctrl #(.FIFO_W(FIFO_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdWrite  (cmdWrite),
    .cmdOp     (cmdByte[3:0]),
    .atnFlag   (cmdByte[ATN_BIT]),
    .fifoLevel (fifoLevel),
    .busyLine  (busyLine),
    .busPhase  (busPhase),
    .strobes   (strobes)
  );

  seqcmd_datapath #(.CNT_W(CNT_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .cmdByte     (cmdByte),
    .xferCount   (xferCount),
    .seqStart    (seqStart),
    .seqState    (seqState),
    .xferLen     (xferLen),
    .curCmd      (curCmd),
    .dmaMode     (dmaMode),
    .atnReq      (atnReq),
    .parityEn    (parityEn),
    .phaseWarn   (phaseWarn),
    .ackRelease  (ackRelease),
    .fifoFlush   (fifoFlush),
    .softReset   (softReset),
    .irqDoneClr  (irqDoneClr),
    .irqDoneSet  (irqDoneSet),
    .irqExcSet   (irqExcSet),
    .excPhaseSet (excPhaseSet)
  );

endmodule

// File: tb/tb_scsi_seq_cmd_decoder.sv
module tb_scsi_seq_cmd_decoder;

  localparam int CNT_W  = 16;
  localparam int FIFO_W = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cmdWrite = 1'b0;
  logic [7:0]        cmdByte = '0;
  logic [CNT_W-1:0]  xferCount = '0;
  logic [FIFO_W-1:0] fifoLevel = '0;
  logic              busyLine = 1'b0;
  logic [2:0]        busPhase = '0;
  logic              seqStart, dmaMode, atnReq, parityEn, phaseWarn, ackRelease;
  logic              fifoFlush, softReset, irqDoneClr, irqDoneSet, irqExcSet, excPhaseSet;
  logic [3:0]        seqState;
  logic [CNT_W:0]    xferLen;
  logic [7:0]        curCmd;

  int  nChecks = 0;
  int  nFail = 0;
  bit  finished = 1'b0;

  logic            mParity = 1'b0;
  logic            mAtn = 1'b0;
  logic [CNT_W:0]  mLen = '0;
  logic [7:0]      mCur = '0;

  always #10 clk = ~clk;

  scsi_seq_cmd_decoder #(.CNT_W(CNT_W), .FIFO_W(FIFO_W)) dut (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .cmdByte(cmdByte),
    .xferCount(xferCount), .fifoLevel(fifoLevel), .busyLine(busyLine),
    .busPhase(busPhase), .seqStart(seqStart), .seqState(seqState),
    .xferLen(xferLen), .curCmd(curCmd), .dmaMode(dmaMode), .atnReq(atnReq),
    .parityEn(parityEn), .phaseWarn(phaseWarn), .ackRelease(ackRelease),
    .fifoFlush(fifoFlush), .softReset(softReset), .irqDoneClr(irqDoneClr),
    .irqDoneSet(irqDoneSet), .irqExcSet(irqExcSet), .excPhaseSet(excPhaseSet)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] phaseFor(input int op);
    case (op)
      3: return 3'b010;
      4: return 3'b011;
      5: return 3'b000;
      6: return 3'b001;
      7: return 3'b110;
      8: return 3'b111;
      default: return 3'b101;
    endcase
  endfunction

  function automatic logic [3:0] stateFor(input int op);
    case (op)
      1: return 4'd1;
      2: return 4'd2;
      3: return 4'd3;
      4: return 4'd4;
      5, 6: return 4'd5;
      7: return 4'd6;
      8: return 4'd7;
      default: return 4'd0;
    endcase
  endfunction

  task automatic checkIdle(input string tag);
    chk({tag, " seqStart"}, 32'(seqStart), 0);
    chk({tag, " seqState"}, 32'(seqState), 0);
    chk({tag, " phaseWarn"}, 32'(phaseWarn), 0);
    chk({tag, " ackRelease"}, 32'(ackRelease), 0);
    chk({tag, " fifoFlush"}, 32'(fifoFlush), 0);
    chk({tag, " softReset"}, 32'(softReset), 0);
    chk({tag, " irqDoneClr"}, 32'(irqDoneClr), 0);
    chk({tag, " irqDoneSet"}, 32'(irqDoneSet), 0);
    chk({tag, " irqExcSet"}, 32'(irqExcSet), 0);
    chk({tag, " excPhaseSet"}, 32'(excPhaseSet), 0);
  endtask

  task automatic checkHeld(input string tag);
    chk({tag, " R1 curCmd"}, 32'(curCmd), 32'(mCur));
    chk({tag, " R1 dmaMode"}, 32'(dmaMode), 32'(mCur[7]));
    chk({tag, " R3 atnReq"}, 32'(atnReq), 32'(mAtn));
    chk({tag, " R5 xferLen"}, 32'(xferLen), 32'(mLen));
    chk({tag, " R11 parityEn"}, 32'(parityEn), 32'(mParity));
  endtask

  task automatic doWrite(input logic [7:0] cmd, input logic [CNT_W-1:0] cnt,
                         input logic [FIFO_W-1:0] lvl, input logic busy, input logic [2:0] ph);
    int  op;
    logic expStart, expWarn, expDone, expExc, expFlush;
    string doneTag;
    op = int'(cmd[3:0]);
    @(negedge clk);
    cmdWrite  = 1'b1;
    cmdByte   = cmd;
    xferCount = cnt;
    fifoLevel = lvl;
    busyLine  = busy;
    busPhase  = ph;
    @(posedge clk);
    @(negedge clk);
    cmdWrite = 1'b0;
    // model update
    mCur = (op == 14) ? 8'h00 : cmd;
    if (op == 2) mAtn = cmd[5];
    if (op == 10) mParity = 1'b1;
    if (op == 11) mParity = 1'b0;
    if (op == 5 || op == 6) mLen = (cnt == 0) ? (CNT_W + 1)'(1) << CNT_W : {1'b0, cnt};
    if (op == 4 || op == 7 || op == 8) mLen = {1'b0, cnt};
    expStart = (op >= 1 && op <= 8) && !(op == 3 && lvl == 0);
    expWarn  = (op >= 3 && op <= 8) && (ph != phaseFor(op));
    expDone  = (op == 9 && !busy) || op == 12 || op == 13 || op == 14;
    expExc   = (op == 9 && busy);
    expFlush = (op == 14 || op == 15);
    doneTag  = (op == 9) ? "R7" : (op == 14) ? "R8" : (op == 0) ? "R13" : "R9";
    checkHeld("write");
    chk("R2 irqDoneClr", 32'(irqDoneClr), 1);
    chk((op == 3) ? "R6 seqStart" : "R4 seqStart", 32'(seqStart), 32'(expStart));
    chk("R4 seqState", 32'(seqState), expStart ? 32'(stateFor(op)) : 0);
    chk("R12 phaseWarn", 32'(phaseWarn), 32'(expWarn));
    chk("R7 ackRelease", 32'(ackRelease), 32'(op == 9));
    chk("R7 excPhaseSet", 32'(excPhaseSet), 32'(expExc));
    chk("R7 irqExcSet", 32'(irqExcSet), 32'(expExc));
    chk({doneTag, " irqDoneSet"}, 32'(irqDoneSet), 32'(expDone));
    chk((op == 15) ? "R10 fifoFlush" : "R8 fifoFlush", 32'(fifoFlush), 32'(expFlush));
    chk("R8 softReset", 32'(softReset), 32'(op == 14));
    // one cycle later: pulses gone, state held
    @(posedge clk);
    @(negedge clk);
    checkIdle("R13 after");
    checkHeld("after");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R13 reset");
    checkHeld("R13 reset");

    // directed corners
    doWrite(8'h05, 16'h0000, 5'd4, 1'b0, 3'b000); // R5 data out, zero means 65536
    doWrite(8'h86, 16'h0001, 5'd4, 1'b0, 3'b001); // R5 data in, count 1, DMA flag
    doWrite(8'h04, 16'h0000, 5'd0, 1'b0, 3'b011); // R5 status keeps zero
    doWrite(8'h03, 16'h0010, 5'd0, 1'b0, 3'b010); // R6 empty FIFO: no start
    doWrite(8'h22, 16'h0000, 5'd0, 1'b0, 3'b000); // R3 select with ATN
    doWrite(8'h0A, 16'h0000, 5'd0, 1'b0, 3'b000); // R11 parity on
    doWrite(8'h8E, 16'h0000, 5'd0, 1'b1, 3'b000); // R8 soft reset keeps parity and ATN
    doWrite(8'h09, 16'h0000, 5'd0, 1'b1, 3'b000); // R7 busy
    doWrite(8'h09, 16'h0000, 5'd0, 1'b0, 3'b000); // R7 idle bus

    // near-exhaustive sweep over all command bytes
    for (int cmd = 0; cmd < 256; cmd++) begin
      for (int v = 0; v < 8; v++) begin
        logic busy;
        logic match;
        logic [CNT_W-1:0] cnt;
        logic [FIFO_W-1:0] lvl;
        logic [2:0] ph;
        busy  = v[0];
        match = v[1];
        cnt   = v[2] ? CNT_W'(cmd * 257 + 3) : '0;
        lvl   = (v[2] ^ v[0]) ? '0 : FIFO_W'(7);
        ph    = match ? phaseFor(cmd % 16) : (phaseFor(cmd % 16) ^ 3'b100);
        doWrite(8'(cmd), cnt, lvl, busy, ph);
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

endmodule